// File: doc/BRIEF.md
# Multicycle INT8 Tensor MAC Sequencer

This block carries out one tensor multiply-accumulate command from start to finish, with no further instructions after the start. A start pulse supplies two operand base addresses, a stride for each operand, a row count, a step count and a clear flag. From then on the internal sequencer issues one operand address pair per cycle. For each address pair the read port returns a 512-bit A beat and a 512-bit B beat. The block forms 64 signed INT8 products from each pair and folds them into a bank of 32-bit accumulators held in local registers.

The accumulator bank has 32 entries of 256 bits, and each entry is split into eight 32-bit lanes. Row r of the command accumulates into entry r. Lane j of that entry gains an eight-term dot product taken from bytes 8j to 8j+7 of the A and B beats. While the command runs, the block holds a clock-gate request so that the scalar front end and the scalar units can stop. At the end it pulses done, and the accumulators can then be read back through a combinational read port.

The read port is a simple valid handshake. The block presents addresses together with `req_valid_o`. The memory returns the beat with `rsp_valid_i` in the same cycle. A cycle without valid data stalls the walk in place. Fetch overlaps with compute, so the peak rate is one beat per cycle.

Top module: `tmac_seq`

## Requirements
- R1: After reset, `gate_o`, `done_o` and `req_valid_o` are low and every lane of all 32 accumulator entries reads zero.
- R2: `start_i` is accepted only while `gate_o` is low. The cycle after acceptance, `gate_o` and `req_valid_o` are high, and they stay high until the final beat is taken. A `start_i` pulse, or a change of command inputs, while `gate_o` is high has no effect.
- R3: On each accepted beat (`req_valid_o` and `rsp_valid_i` both high), lane j (bits 32j+31:32j) of the current row's entry gains the sum over t=0..7 of A byte (8j+t) times B byte (8j+t). Byte i sits at bits 8i+7:8i, and both bytes are signed two's complement and sign-extended to 32 bits. This gives 64 products per beat.
- R4: Accumulation wraps modulo 2^32 with no saturation.
- R5: Beats are taken row-major: for row r = 0..rows-1, then step k = 0..steps-1. The A address is `a_base + r*a_stride + 64*k` and the B address is `b_base + k*b_stride`. Rows = `rows_m1_i+1`, 1 to 32. Steps = `cols_m1_i+1`, 1 to 256.
- R6: In a busy cycle with `rsp_valid_i` low, no beat is taken, the addresses hold, and the accumulators are unchanged.
- R7: With the clear flag set at start, the step-0 beat of each row overwrites that row's entry with its dot products. Without the flag it adds to the existing value. Entries at or above the row count are never written.
- R8: `done_o` is high for exactly one cycle, the cycle after the final beat is accepted. `gate_o` falls in that same cycle. With `rsp_valid_i` held high, a command is busy for exactly rows×steps cycles.
- R9: `rd_data_o` shows entry `rd_idx_i` combinationally, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a command when idle |
| a_base_i | input | 32 | A operand base address |
| a_stride_i | input | 32 | A address step between rows |
| b_base_i | input | 32 | B operand base address |
| b_stride_i | input | 32 | B address step between steps |
| rows_m1_i | input | 5 | Row count minus one |
| cols_m1_i | input | 8 | Step count minus one |
| clear_i | input | 1 | Overwrite entries on step 0 |
| req_valid_o | output | 1 | Address pair valid |
| req_addr_a_o | output | 32 | A beat address |
| req_addr_b_o | output | 32 | B beat address |
| rsp_valid_i | input | 1 | Beats for the current addresses present |
| rsp_a_i | input | 512 | A beat, 64 signed bytes |
| rsp_b_i | input | 512 | B beat, 64 signed bytes |
| gate_o | output | 1 | Clock-gate request, high while busy |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rd_idx_i | input | 5 | Readback entry index |
| rd_data_o | output | 256 | Readback entry, eight 32-bit lanes |

## Verification
The assertions rely on the memory model returning beats only against the addresses currently presented. They also rely on `rsp_valid_i` being a plain per-cycle level with no obligation to become ready. The stall and done properties therefore hold under any valid pattern.

The bench drives the response data combinationally from the presented addresses and changes `rsp_valid_i` and `start_i` only at the falling edge. It pulses `start_i` both while idle and while busy, so the ignored-start case sits inside the same legal stimulus space.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned ELEM_W   = 8;
  localparam int unsigned BEAT_W   = 512;
  localparam int unsigned LANE_W   = 32;
  localparam int unsigned LANES    = 8;
  localparam int unsigned ENTRIES  = 32;
  localparam int unsigned COL_W    = 8;
  localparam int unsigned IDX_W    = $clog2(ENTRIES);
  localparam int unsigned ENT_W    = LANES * LANE_W;
  localparam int unsigned PER_LANE = BEAT_W / ELEM_W / LANES;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/tmac_addr_gen.sv
module tmac_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned BEAT_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] a_base_i,
  input  logic [ADDR_W-1:0] a_stride_i,
  input  logic [ADDR_W-1:0] b_base_i,
  input  logic [ADDR_W-1:0] b_stride_i,
  input  logic [IDX_W-1:0]  rows_m1_i,
  input  logic [COL_W-1:0]  cols_m1_i,
  output logic [IDX_W-1:0]  row_o,
  output logic              first_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BEAT_BYTES);

  logic [IDX_W-1:0]  row_q, rows_m1_q;
  logic [COL_W-1:0]  col_q, cols_m1_q;
  logic [ADDR_W-1:0] a_row_q, a_q, b_q;
  logic [ADDR_W-1:0] a_stride_q, b_stride_q, b_base_q;
  logic              row_end;

  assign row_end = (col_q == cols_m1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q      <= '0;
      col_q      <= '0;
      rows_m1_q  <= '0;
      cols_m1_q  <= '0;
      a_row_q    <= '0;
      a_q        <= '0;
      b_q        <= '0;
      a_stride_q <= '0;
      b_stride_q <= '0;
      b_base_q   <= '0;
    end else if (load_i) begin
      row_q      <= '0;
      col_q      <= '0;
      rows_m1_q  <= rows_m1_i;
      cols_m1_q  <= cols_m1_i;
      a_row_q    <= a_base_i;
      a_q        <= a_base_i;
      b_q        <= b_base_i;
      a_stride_q <= a_stride_i;
      b_stride_q <= b_stride_i;
      b_base_q   <= b_base_i;
    end else if (adv_i) begin
      if (row_end) begin
        col_q   <= '0;
        row_q   <= row_q + IDX_W'(1);
        a_row_q <= a_row_q + a_stride_q;
        a_q     <= a_row_q + a_stride_q;
        b_q     <= b_base_q;
      end else begin
        col_q <= col_q + COL_W'(1);
        a_q   <= a_q + STEP_A;
        b_q   <= b_q + b_stride_q;
      end
    end
  end

  assign row_o    = row_q;
  assign first_o  = (col_q == '0);
  assign last_o   = row_end && (row_q == rows_m1_q);
  assign addr_a_o = a_q;
  assign addr_b_o = b_q;
endmodule

// File: rtl/tmac_dot_array.sv
module tmac_dot_array #(
  parameter int unsigned ELEM_W   = 8,
  parameter int unsigned LANES    = 8,
  parameter int unsigned PER_LANE = 8,
  parameter int unsigned LANE_W   = 32
) (
  input  logic [LANES*PER_LANE*ELEM_W-1:0] a_i,
  input  logic [LANES*PER_LANE*ELEM_W-1:0] b_i,
  output logic [LANES*LANE_W-1:0]          sum_o
);
  localparam int unsigned EXT = LANE_W - ELEM_W;

  function automatic logic [LANE_W-1:0] sext(input logic [ELEM_W-1:0] v);
    return {{EXT{v[ELEM_W-1]}}, v};
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int t = 0; t < PER_LANE; t++) begin
        acc = acc + sext(a_i[(l*PER_LANE+t)*ELEM_W +: ELEM_W])
                  * sext(b_i[(l*PER_LANE+t)*ELEM_W +: ELEM_W]);
      end
    end
    assign sum_o[l*LANE_W +: LANE_W] = acc;
  end
endmodule

// File: rtl/tmac_acc_bank.sv
module tmac_acc_bank #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 32,
  parameter int unsigned ENT_W   = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             overwrite_i,
  input  logic [ENT_W-1:0] delta_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_data_o
);
  logic [ENT_W-1:0] mem_q [ENTRIES];
  logic [ENT_W-1:0] old_ent, new_ent;

  assign old_ent = mem_q[wr_idx_i];

  // lane-wise add, no carry between lanes
  for (genvar l = 0; l < LANES; l++) begin : g_add
    assign new_ent[l*LANE_W +: LANE_W] =
      (overwrite_i ? '0 : old_ent[l*LANE_W +: LANE_W]) + delta_i[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= new_ent;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tmac_seq.sv
module tmac_seq
  import tmac_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned BW  = BEAT_W,
  parameter int unsigned IW  = IDX_W,
  parameter int unsigned CW  = COL_W,
  parameter int unsigned EW  = ENT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_base_i,
  input  logic [AW-1:0] a_stride_i,
  input  logic [AW-1:0] b_base_i,
  input  logic [AW-1:0] b_stride_i,
  input  logic [IW-1:0] rows_m1_i,
  input  logic [CW-1:0] cols_m1_i,
  input  logic          clear_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_a_o,
  output logic [AW-1:0] req_addr_b_o,
  input  logic          rsp_valid_i,
  input  logic [BW-1:0] rsp_a_i,
  input  logic [BW-1:0] rsp_b_i,
  output logic          gate_o,
  output logic          done_o,
  input  logic [IW-1:0] rd_idx_i,
  output logic [EW-1:0] rd_data_o
);
  seq_state_e        state_q;
  logic              done_q, clear_q;
  logic              load, take, first, last;
  logic [IW-1:0]     row;
  logic [EW-1:0]     delta;

  assign load = start_i && (state_q == ST_IDLE);
  assign take = (state_q == ST_RUN) && rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      done_q <= take && last;
      if (load) begin
        state_q <= ST_RUN;
        clear_q <= clear_i;
      end else if (take && last) begin
        state_q <= ST_IDLE;
      end
    end
  end

  tmac_addr_gen #(
    .ADDR_W(AW), .IDX_W(IW), .COL_W(CW), .BEAT_BYTES(BW/8)
  ) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .adv_i(take),
    .a_base_i(a_base_i), .a_stride_i(a_stride_i),
    .b_base_i(b_base_i), .b_stride_i(b_stride_i),
    .rows_m1_i(rows_m1_i), .cols_m1_i(cols_m1_i),
    .row_o(row), .first_o(first), .last_o(last),
    .addr_a_o(req_addr_a_o), .addr_b_o(req_addr_b_o)
  );

  tmac_dot_array #(
    .ELEM_W(ELEM_W), .LANES(LANES), .PER_LANE(PER_LANE), .LANE_W(LANE_W)
  ) u_dot (
    .a_i(rsp_a_i), .b_i(rsp_b_i), .sum_o(delta)
  );

  tmac_acc_bank #(
    .ENTRIES(ENTRIES), .IDX_W(IW), .LANES(LANES), .LANE_W(LANE_W), .ENT_W(EW)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(take), .wr_idx_i(row),
    .overwrite_i(clear_q && first), .delta_i(delta),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  assign gate_o      = (state_q == ST_RUN);
  assign req_valid_o = (state_q == ST_RUN);
  assign done_o      = done_q;
endmodule

// File: rtl/tmac_seq_chk.sv
module tmac_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rsp_valid_i,
  input logic          gate_o,
  input logic          done_o,
  input logic [AW-1:0] req_addr_a_o,
  input logic [AW-1:0] req_addr_b_o
);
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_o && start_i |=> gate_o); // R2
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_o && !start_i |=> !gate_o); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o && !rsp_valid_i |=> gate_o && $stable(req_addr_a_o) && $stable(req_addr_b_o)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !gate_o && $past(gate_o) && $past(rsp_valid_i)); // R8
  AST_FALL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> done_o); // R8
endmodule

bind tmac_seq tmac_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rsp_valid_i(rsp_valid_i),
  .gate_o(gate_o), .done_o(done_o),
  .req_addr_a_o(req_addr_a_o), .req_addr_b_o(req_addr_b_o)
);

// File: tb/tmac_seq_bench.sv
module tmac_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  a_base_i = '0, a_stride_i = '0, b_base_i = '0, b_stride_i = '0;
  logic [4:0]   rows_m1_i = '0;
  logic [7:0]   cols_m1_i = '0;
  logic         clear_i = 1'b0;
  logic         req_valid_o;
  logic [31:0]  req_addr_a_o, req_addr_b_o;
  logic         rsp_valid_i = 1'b0;
  logic [511:0] rsp_a_i, rsp_b_i;
  logic         gate_o, done_o;
  logic [4:0]   rd_idx_i = '0;
  logic [255:0] rd_data_o;

  int  n_checks = 0, n_err = 0;
  bit  ext_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state
  bit  m_busy = 0, m_done = 0, c_clear = 0;
  int  m_r = 0, m_k = 0, c_rows = 1, c_cols = 1;
  logic [31:0] c_a_base, c_a_str, c_b_base, c_b_str;
  int  m_acc [32][8];
  int  tick = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmac_seq u_tmac_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_base_i(a_base_i), .a_stride_i(a_stride_i), .b_base_i(b_base_i), .b_stride_i(b_stride_i),
    .rows_m1_i(rows_m1_i), .cols_m1_i(cols_m1_i), .clear_i(clear_i),
    .req_valid_o(req_valid_o), .req_addr_a_o(req_addr_a_o), .req_addr_b_o(req_addr_b_o),
    .rsp_valid_i(rsp_valid_i), .rsp_a_i(rsp_a_i), .rsp_b_i(rsp_b_i),
    .gate_o(gate_o), .done_o(done_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] addr, input int i,
                                          input bit ext, input logic [7:0] salt);
    if (ext) return 8'h80;
    return (addr[7:0] ^ (addr[15:8] + 8'(i * 37))) ^ salt;
  endfunction

  always_comb begin
    for (int i = 0; i < 64; i++) begin
      rsp_a_i[8*i +: 8] = mem_byte(req_addr_a_o, i, ext_mode, 8'h5A);
      rsp_b_i[8*i +: 8] = mem_byte(req_addr_b_o, i, ext_mode, 8'hC3);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_a();
    return c_a_base + 32'(m_r) * c_a_str + 32'(m_k * 64);
  endfunction
  function automatic logic [31:0] exp_b();
    return c_b_base + 32'(m_k) * c_b_str;
  endfunction

  task automatic model_step(input bit v, input bit st);
    m_done = 0;
    if (m_busy) begin
      if (v) begin
        logic [31:0] aa, bb;
        aa = exp_a();
        bb = exp_b();
        for (int j = 0; j < 8; j++) begin
          int s = 0;
          for (int t = 0; t < 8; t++)
            s += int'($signed(mem_byte(aa, 8*j+t, ext_mode, 8'h5A)))
               * int'($signed(mem_byte(bb, 8*j+t, ext_mode, 8'hC3)));
          if (c_clear && m_k == 0) m_acc[m_r][j] = s;
          else m_acc[m_r][j] = m_acc[m_r][j] + s;
        end
        if (m_k == c_cols - 1) begin
          m_k = 0;
          if (m_r == c_rows - 1) begin m_busy = 0; m_done = 1; end
          else m_r++;
        end else m_k++;
      end
    end else if (st) begin
      m_busy = 1; m_r = 0; m_k = 0;
      c_a_base = a_base_i; c_a_str = a_stride_i;
      c_b_base = b_base_i; c_b_str = b_stride_i;
      c_rows = int'(rows_m1_i) + 1; c_cols = int'(cols_m1_i) + 1;
      c_clear = clear_i;
    end
  endtask

  task automatic compare_all();
    logic [255:0] e;
    int idx;
    chk(gate_o == m_busy, "R2 gate_o", 256'(gate_o), 256'(m_busy));
    chk(req_valid_o == m_busy, "R2 req_valid_o", 256'(req_valid_o), 256'(m_busy));
    chk(done_o == m_done, "R8 done_o", 256'(done_o), 256'(m_done));
    if (m_busy) begin
      chk(req_addr_a_o == exp_a(), "R5/R6 addr_a", 256'(req_addr_a_o), 256'(exp_a()));
      chk(req_addr_b_o == exp_b(), "R5/R6 addr_b", 256'(req_addr_b_o), 256'(exp_b()));
    end
    idx = tick % 32;
    rd_idx_i = 5'(idx);
    #1;
    for (int j = 0; j < 8; j++) e[32*j +: 32] = 32'(m_acc[idx][j]);
    chk(rd_data_o == e, "R3/R7/R9 entry", rd_data_o, e);
    tick++;
  endtask

  task automatic cyc(input bit v, input bit st);
    rsp_valid_i = v;
    start_i = st;
    @(posedge clk_i);
    @(negedge clk_i);
    model_step(v, st);
    compare_all();
  endtask

  task automatic run_cmd(input logic [31:0] ab, input logic [31:0] as, input logic [31:0] bb,
                         input logic [31:0] bs, input int rows, input int cols,
                         input bit clr, input bit rnd, input bit poke);
    int n = 0;
    a_base_i = ab; a_stride_i = as; b_base_i = bb; b_stride_i = bs;
    rows_m1_i = 5'(rows - 1); cols_m1_i = 8'(cols - 1); clear_i = clr;
    cyc(1'b0, 1'b1);
    while (m_busy && n < 20000) begin
      bit v, st;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v  = rnd ? (lfsr[0] | lfsr[1]) : 1'b1;
      st = poke && (n == 2);
      if (st) begin a_base_i = 32'hDEAD0000; rows_m1_i = 5'd31; clear_i = ~clr; end
      cyc(v, st);
      n++;
    end
    if (!rnd) chk(n == rows * cols, "R8 busy cycles", 256'(n), 256'(rows * cols));
    cyc(1'b0, 1'b0);
  endtask

  initial begin
    for (int e = 0; e < 32; e++) for (int j = 0; j < 8; j++) m_acc[e][j] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state over all entries
    chk(gate_o == 0 && done_o == 0 && req_valid_o == 0, "R1 outputs idle",
        256'({gate_o, done_o, req_valid_o}), 256'(0));
    for (int e = 0; e < 32; e++) begin
      rd_idx_i = 5'(e);
      #1;
      chk(rd_data_o == '0, "R1 entry zero", rd_data_o, '0);
    end
    cyc(1'b0, 1'b0);
    run_cmd(32'h0000_1000, 32'h0000_0400, 32'h0008_0000, 32'h0000_0040, 4, 5, 1, 0, 0);
    run_cmd(32'h0001_2340, 32'h0000_0200, 32'h0009_1000, 32'h0000_0080, 3, 7, 0, 1, 0);
    run_cmd(32'h0002_0000, 32'h0000_0100, 32'h000A_0000, 32'h0000_0020, 2, 6, 1, 1, 1); // R2 ignored start
    run_cmd(32'h0003_0000, 32'h0000_0040, 32'h000B_0000, 32'h0000_0000, 1, 1, 0, 0, 0);
    run_cmd(32'h0004_0000, 32'h0000_0080, 32'h000C_0000, 32'h0000_0100, 32, 1, 1, 0, 0);
    run_cmd(32'h0005_0000, 32'h0001_0000, 32'h000D_0000, 32'h0000_0040, 1, 256, 0, 1, 0);
    run_cmd(32'h0006_0000, 32'h0000_0800, 32'h000E_0000, 32'h0000_0040, 2, 3, 1, 0, 0); // R7
    // R4: 65 x 256 beats of (+16384 x 8) into entry 0 wraps past 2^31
    ext_mode = 1'b1;
    run_cmd(32'h0, 32'h0, 32'h0, 32'h0, 1, 256, 1, 0, 0);
    for (int c = 0; c < 64; c++) run_cmd(32'h0, 32'h0, 32'h0, 32'h0, 1, 256, 0, 0, 0);
    rd_idx_i = 5'd0;
    #1;
    chk(rd_data_o[31:0] == 32'h8200_0000, "R4 wrap lane0", 256'(rd_data_o[31:0]),
        256'(32'h8200_0000));
    ext_mode = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule